// File: doc/BRIEF.md
# Coherent Split-Word Result Readback

This block is the register-read front end of a multi-channel converter. The converter yields 10-bit results, but the host sees them through 8-bit registers. Each channel's upper eight bits sit in a register of their own. The two low bits of each channel are packed into a shared low-part register, and one such register serves a whole channel group. Group 0 holds channels 0 and 1. Group 1 holds channels 2 to 5.

A host that wants a full 10-bit value reads the group's low-part register first. That read freezes every channel of the group, so the high parts the host reads afterwards belong to the same conversions. Results that arrive while a group is frozen are parked in shadow storage. The freeze ends when the host reads any high-part register of that group, and at that moment the parked results become visible. A host that only needs 8 bits reads the high-part register alone, and no freeze occurs. Read data is registered and appears one cycle after the read strobe.

Top module: `rbk_readback`

## Requirements
- R1: After reset, every result reads 00h, no group is frozen, and rdData is 00h.
- R2: A read issued with rdEn in cycle N places its data on rdData after the clock edge that ends cycle N. rdData holds its value in every cycle without rdEn. The high-part register of channel c is at address 08h+c and returns result bits [9:2].
- R3: The low-part register of group 0 is at 04h and the one for group 1 is at 05h. The channel at position k inside its group occupies bits [2k+1:2k], with bits [1:0] holding the group's lowest channel. Unused bits read 0.
- R4: When a group is not frozen, a result delivered on updValid/updData at a clock edge is returned by any read issued after that edge.
- R5: A low-part read freezes its own group. From then on, updates to the group's channels, including an update in the same cycle as that read, do not change what its registers return until the freeze ends.
- R6: A high-part read of a frozen group returns the frozen value and ends the freeze. After that, each channel shows its latest result. An update in the same cycle as the releasing read wins over a parked one.
- R7: A high-part read of a group that is not frozen freezes nothing, and later updates stay visible.
- R8: A low-part read of one group leaves the freeze state of the other group unchanged.
- R9: A read of any other address (00h–03h, 06h, 07h, 0Eh–FFh) returns 00h and changes no freeze state.
- R10: Reading a frozen group's low-part register again keeps the freeze and returns the frozen low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read strobe, one cycle per read |
| rdAddr | input | 8 | Register address of the read |
| rdData | output | 8 | Registered read data |
| updValid | input | 6 | Per-channel new-result strobe |
| updData | input | 60 | Per-channel 10-bit results, channel c at [10c+9:10c] |

## Verification
Two things can happen in the same cycle: a read that changes the freeze state of a group, and a new result landing on a channel of that group. The bench provokes this on purpose. It pairs a low-part read with an update, and it pairs a releasing high-part read with an update while an older result is parked. After each pair it reads the channel back twice. The first read must return the pre-update value. The second must return the newest result. A behavioural model that is updated every clock judges these reads, and a long random mix of reads and updates adds more such collisions.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
  parameter int NUM_CH   = 6;
  parameter int RES_W    = 10;
  parameter int REG_W    = 8;
  parameter int LOW_W    = RES_W - REG_W;
  parameter int NUM_GRP  = 2;
  parameter int GRP0_CH  = 2;
  parameter int ADDR_W   = 8;
  parameter int LSB_BASE = 4;
  parameter int MSB_BASE = 8;
  parameter int CH_IW    = $clog2(NUM_CH);
  parameter int GRP_IW   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  function automatic int grpOf(input int ch);
    return (ch < GRP0_CH) ? 0 : 1;
  endfunction

  function automatic int slotOf(input int ch);
    return (ch < GRP0_CH) ? ch : ch - GRP0_CH;
  endfunction

  typedef struct packed {
    logic [NUM_GRP-1:0] freeze;
    logic [NUM_GRP-1:0] unfreeze;
    logic [NUM_GRP-1:0] hold;
    logic               rdStrobe;
    logic               rdIsLsb;
    logic               rdIsMsb;
    logic [GRP_IW-1:0]  lsbGrp;
    logic [CH_IW-1:0]   msbCh;
  } rbkStrobe_t;
endpackage

// File: rtl/rbk_ctrl.sv
module rbk_ctrl
  import rbk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output rbkStrobe_t         strobe,
  output logic [NUM_GRP-1:0] lockQ
);
  rbkStrobe_t st;

  always_comb begin
    st = '0;
    st.rdStrobe = rdEn;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (rdEn && rdAddr == ADDR_W'(LSB_BASE + g)) begin
        st.rdIsLsb   = 1'b1;
        st.lsbGrp    = GRP_IW'(g);
        st.freeze[g] = 1'b1;
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (rdEn && rdAddr == ADDR_W'(MSB_BASE + c)) begin
        st.rdIsMsb = 1'b1;
        st.msbCh   = CH_IW'(c);
        if (lockQ[grpOf(c)]) st.unfreeze[grpOf(c)] = 1'b1;
      end
    end
    st.hold = (lockQ & ~st.unfreeze) | st.freeze;
  end

  assign strobe = st;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockQ <= '0;
    else       lockQ <= (lockQ | st.freeze) & ~st.unfreeze;
  end
endmodule

// File: rtl/rbk_dpath.sv
module rbk_dpath
  import rbk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  rbkStrobe_t              strobe,
  input  logic [NUM_CH-1:0]       updValid,
  input  logic [NUM_CH*RES_W-1:0] updData,
  output logic [NUM_CH*RES_W-1:0] visFlat,
  output logic [REG_W-1:0]        rdData
);
  logic [REG_W-1:0] rdNext;

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    localparam int G = grpOf(c);
    logic [RES_W-1:0] visQ, shdQ;
    logic             pendQ;
    logic [RES_W-1:0] inVal;
    assign inVal = updData[c*RES_W +: RES_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        visQ  <= '0;
        shdQ  <= '0;
        pendQ <= 1'b0;
      end else if (strobe.unfreeze[G]) begin
        if (updValid[c])  visQ <= inVal;
        else if (pendQ)   visQ <= shdQ;
        pendQ <= 1'b0;
      end else if (updValid[c]) begin
        if (strobe.hold[G]) begin
          shdQ  <= inVal;
          pendQ <= 1'b1;
        end else begin
          visQ <= inVal;
        end
      end
    end

    assign visFlat[c*RES_W +: RES_W] = visQ;
  end

  always_comb begin
    rdNext = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (strobe.rdIsMsb && strobe.msbCh == CH_IW'(c))
        rdNext = visFlat[c*RES_W+LOW_W +: REG_W];
      if (strobe.rdIsLsb && strobe.lsbGrp == GRP_IW'(grpOf(c)))
        rdNext[slotOf(c)*LOW_W +: LOW_W] = visFlat[c*RES_W +: LOW_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strobe.rdStrobe) rdData <= rdNext;
  end
endmodule

// File: rtl/rbk_readback.sv
module rbk_readback
  import rbk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rdEn,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [REG_W-1:0]        rdData,
  input  logic [NUM_CH-1:0]       updValid,
  input  logic [NUM_CH*RES_W-1:0] updData
);
  rbkStrobe_t               strobe;
  logic [NUM_GRP-1:0]       lockQ;
  logic [NUM_CH*RES_W-1:0]  visFlat;

  rbk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr),
    .strobe(strobe), .lockQ(lockQ)
  );

  rbk_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .updValid(updValid),
    .updData(updData), .visFlat(visFlat), .rdData(rdData)
  );
endmodule

// File: rtl/rbk_checker.sv
module rbk_checker
  import rbk_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    rdEn,
  input logic [ADDR_W-1:0]       rdAddr,
  input logic [REG_W-1:0]        rdData,
  input logic [NUM_GRP-1:0]      lockQ,
  input logic [NUM_CH*RES_W-1:0] visFlat
);
  logic               mapped;
  logic [NUM_GRP-1:0] grpMsbRd;

  always_comb begin
    mapped   = 1'b0;
    grpMsbRd = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (rdAddr == ADDR_W'(LSB_BASE + g)) mapped = 1'b1;
    for (int c = 0; c < NUM_CH; c++)
      if (rdAddr == ADDR_W'(MSB_BASE + c)) begin
        mapped = 1'b1;
        if (rdEn) grpMsbRd[grpOf(c)] = 1'b1;
      end
  end

  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !mapped |=> rdData == '0); // R9
  AST_UNMAPPED_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !mapped |=> lockQ == $past(lockQ)); // R9

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    AST_LSB_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
      rdEn && rdAddr == ADDR_W'(LSB_BASE + g) |=> lockQ[g]); // R5
    for (genvar h = 0; h < NUM_GRP; h++) begin : gOther
      if (h != g) begin : gNe
        AST_OTHER_GRP_KEPT: assert property (@(posedge clk) disable iff (!rstN)
          rdEn && rdAddr == ADDR_W'(LSB_BASE + g) |=> lockQ[h] == $past(lockQ[h])); // R8
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    localparam int G = grpOf(c);
    AST_MSB_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
      rdEn && rdAddr == ADDR_W'(MSB_BASE + c) && lockQ[G] |=> !lockQ[G]); // R6
    AST_MSB_FIRST_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
      rdEn && rdAddr == ADDR_W'(MSB_BASE + c) && !lockQ[G] |=> !lockQ[G]); // R7
    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      lockQ[G] && !grpMsbRd[G] |=> $stable(visFlat[c*RES_W +: RES_W])); // R5
  end
endmodule

bind rbk_readback rbk_checker u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
  .lockQ(lockQ), .visFlat(visFlat)
);

// File: tb/sim_rbk_readback.sv
module sim_rbk_readback;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic [5:0]  updValid = '0;
  logic [59:0] updData = '0;

  int tests = 0;
  int fails = 0;

  int mVis[6];
  int mShd[6];
  bit mPend[6];
  bit mLock[2];
  int expRd = 0;

  always #4 clk = ~clk;

  rbk_readback u0 (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .updValid(updValid), .updData(updData)
  );

  function automatic int grpFor(int ch);
    return (ch < 2) ? 0 : 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: rdData=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Behavioural reference, advanced once per rising edge.
  task automatic modelEdge(input bit r, input int a, input bit [5:0] um, input bit [59:0] ud);
    bit frz[2];
    bit rel[2];
    int rv;
    frz = '{0, 0};
    rel = '{0, 0};
    if (r) begin
      rv = 0;
      if (a == 4 || a == 5) begin
        frz[a - 4] = 1;
        for (int c = 0; c < 6; c++)
          if (grpFor(c) == a - 4)
            rv |= (mVis[c] & 3) << (2 * ((c < 2) ? c : c - 2));
      end else if (a >= 8 && a <= 13) begin
        rv = (mVis[a - 8] >> 2) & 8'hFF;
        if (mLock[grpFor(a - 8)]) rel[grpFor(a - 8)] = 1;
      end
      expRd = rv;
    end
    for (int c = 0; c < 6; c++) begin
      int g = grpFor(c);
      int v = int'(ud[c*10 +: 10]);
      if (rel[g]) begin
        if (um[c]) mVis[c] = v;
        else if (mPend[c]) mVis[c] = mShd[c];
        mPend[c] = 0;
      end else if (um[c]) begin
        if (mLock[g] || frz[g]) begin
          mShd[c] = v;
          mPend[c] = 1;
        end else mVis[c] = v;
      end
    end
    for (int g = 0; g < 2; g++)
      mLock[g] = (mLock[g] || frz[g]) && !rel[g];
  endtask

  task automatic step(input bit r, input int a, input bit [5:0] um, input bit [59:0] ud,
                      input string tag);
    @(negedge clk);
    rdEn = r;
    rdAddr = 8'(a);
    updValid = um;
    updData = ud;
    @(posedge clk);
    modelEdge(r, a, um, ud);
    #1;
    if (r) check({tag, " model"}, int'(rdData), expRd);
  endtask

  task automatic rd(input int a, input string tag);
    step(1, a, '0, '0, tag);
  endtask

  task automatic upd(input int ch, input int val);
    bit [59:0] d = '0;
    d[ch*10 +: 10] = 10'(val);
    step(0, 0, 6'(1 << ch), d, "upd");
  endtask

  task automatic rdUpd(input int a, input int ch, input int val, input string tag);
    bit [59:0] d = '0;
    d[ch*10 +: 10] = 10'(val);
    step(1, a, 6'(1 << ch), d, tag);
  endtask

  task automatic lit(input string tag, input int exp);
    check(tag, int'(rdData), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 6; c++) begin mVis[c] = 0; mShd[c] = 0; mPend[c] = 0; end
    mLock = '{0, 0};
    repeat (3) @(posedge clk);
    #1;
    lit("R1 rdData at reset", 8'h00);
    @(negedge clk); rstN = 1'b1;

    rd(8'h04, "R1"); lit("R1 group0 low part", 8'h00);
    rd(8'h08, "R1"); lit("R1 ch0 high part", 8'h00);

    // R2 / R3 / R4 basic readback
    upd(0, 10'h2F1);
    upd(1, 10'h0C6);
    rd(8'h08, "R4"); lit("R4 ch0 high", 8'hBC);
    step(0, 0, '0, '0, "idle"); lit("R2 rdData held", 8'hBC);
    rd(8'h09, "R2"); lit("R2 ch1 high", 8'h31);
    rd(8'h04, "R3"); lit("R3 group0 packing", 8'h09);
    rd(8'h08, "R6"); lit("R6 release ch0", 8'hBC);

    upd(2, 10'h003);
    upd(5, 10'h3FE);
    rd(8'h05, "R3"); lit("R3 group1 packing", 8'h83);
    upd(5, 10'h100);
    rd(8'h0D, "R5"); lit("R5 frozen ch5", 8'hFF);
    rd(8'h0D, "R6"); lit("R6 parked ch5 shown", 8'h40);

    // R5 update in same cycle as freezing read
    rdUpd(8'h05, 4, 10'h155, "R5"); lit("R5 same-cycle low part", 8'h03);
    rd(8'h0C, "R5"); lit("R5 same-cycle frozen ch4", 8'h00);
    rd(8'h0C, "R6"); lit("R6 ch4 after release", 8'h55);

    // R6 update in same cycle as releasing read
    rd(8'h05, "R6");
    upd(3, 10'h0AA);
    rdUpd(8'h0B, 3, 10'h2C8, "R6"); lit("R6 releasing read frozen", 8'h00);
    rd(8'h0B, "R6"); lit("R6 newest wins", 8'hB2);

    // R7 high part first
    rd(8'h0A, "R7"); lit("R7 ch2 high", 8'h00);
    upd(2, 10'h3C0);
    rd(8'h0A, "R7"); lit("R7 no freeze", 8'hF0);

    // R8 groups independent
    rd(8'h04, "R8");
    upd(2, 10'h040);
    rd(8'h0A, "R8"); lit("R8 group1 unfrozen", 8'h10);
    upd(0, 10'h000);
    rd(8'h08, "R8"); lit("R8 group0 frozen", 8'hBC);
    rd(8'h08, "R8"); lit("R8 group0 released", 8'h00);

    // R9 unmapped
    rd(8'h00, "R9"); lit("R9 addr 00", 8'h00);
    rd(8'h06, "R9"); lit("R9 addr 06", 8'h00);
    rd(8'h0E, "R9"); lit("R9 addr 0E", 8'h00);
    rd(8'hFF, "R9"); lit("R9 addr FF", 8'h00);
    upd(1, 10'h3FF);
    rd(8'h09, "R9"); lit("R9 no freeze", 8'hFF);

    // R10 repeated low-part read
    rd(8'h04, "R10"); lit("R10 first", 8'h0C);
    upd(1, 10'h001);
    rd(8'h04, "R10"); lit("R10 second frozen", 8'h0C);
    rd(8'h09, "R10"); lit("R10 frozen high", 8'hFF);
    rd(8'h04, "R10"); lit("R10 after release", 8'h04);
    rd(8'h08, "R10");

    // random collisions of reads and updates
    for (int i = 0; i < 2000; i++) begin
      bit r = 1'($urandom % 2);
      int sel = $urandom % 10;
      int a = (sel < 2) ? 4 + sel : (sel < 8) ? 8 + sel - 2 : int'($urandom % 256);
      bit [5:0] um = 6'($urandom) & 6'($urandom);
      bit [59:0] ud = {28'($urandom), 32'($urandom)};
      step(r, a, um, ud, "R5/R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule